// File: doc/BRIEF.md
# Restartable Block Copy Engine

The engine moves a run of equal-sized elements from one memory region to another through a single shared memory port. It never touches two locations at once. Each element is first read from the source into an internal holding register, and the next access writes it to the destination. Three architectural registers drive the copy: a source pointer, a destination pointer and a remaining-element count. Software loads them while the engine is idle, picks an element width of 8, 16 or 32 bits, and pulses start.

The copy can be preempted at any element boundary. An interrupt request is honoured only once the write of the current element has been granted. The engine then drops back to idle with an interrupted flag raised. The pointers and the count move after every element, so their live values always describe the work still to do. Pulsing start again without reloading anything resumes the copy: no element is lost and none is written twice. When the count reaches zero, a one-cycle done pulse marks completion.

Top module: `blk_copy_engine`

## Requirements
- R1: The element width is taken from `elem_size` when start is accepted: 00 is 1 byte, 01 is 2 bytes, 10 is 4 bytes, and 11 is treated as 4 bytes. `mem_size` shows the accepted code (11 is shown as 10). After each element's write is granted, both pointers grow by the element width in bytes.
- R2: Each element is read from the source pointer address (`mem_we`=0) and then written to the destination pointer address (`mem_we`=1). The element occupies the low bytes of the data word, little-endian. Lanes of `mem_wdata` above the element width are zero.
- R3: While `mem_req` is high and `mem_gnt` is low, `mem_we`, `mem_addr`, `mem_wdata` and `mem_size` hold their values in the next cycle, and the request stays up. For a read, `mem_rdata` is captured in the cycle in which `mem_gnt` is high.
- R4: The count drops by one per granted write. The cycle after the final write grant, `done` is high for one cycle and `busy` is low.
- R5: A start with a count of zero makes no memory access. `done` is high in the next cycle and `busy` stays low.
- R6: A high `irq` at the write grant of any element other than the final one returns the engine to idle and sets `intr_flag`. A high `irq` during a read does not stop the element before its write. `intr_flag` clears on the next accepted start.
- R7: A start after an interruption, using the live register values, copies exactly the remaining elements. In total, every element is written once.
- R8: If `irq` is high at the final element's write grant, completion wins: `done` pulses and `intr_flag` stays low.
- R9: Configuration writes use `cfg_sel` codes 0 (source pointer), 1 (destination pointer), 2 (count) and 3 (no register). They take effect only while idle and are ignored while busy. `src_ptr`, `dst_ptr` and `count` are readable at all times.
- R10: A start pulse while busy has no effect.
- R11: After reset, `busy`, `done`, `intr_flag` and `mem_req` are low, and the pointers and count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for the write |
| cfg_wdata | input | AW | Register write value |
| elem_size | input | 2 | Element width code, sampled at start |
| start | input | 1 | Start or resume the copy |
| irq | input | 1 | Interrupt request |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| intr_flag | output | 1 | Last run ended by interrupt |
| src_ptr | output | AW | Live source pointer |
| dst_ptr | output | AW | Live destination pointer |
| count | output | CW | Live remaining element count |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write data |
| mem_size | output | 2 | Access width code |
| mem_gnt | input | 1 | Memory grant |
| mem_rdata | input | DW | Read data, valid with grant |

## Verification
Two events can fall on the same clock edge: the final element's write grant and an interrupt request. The bench provokes this by holding `irq` high through a one-element copy and through the last element of a run driven to completion by repeated single-element resumes. It judges the outcome by requiring a done pulse, a cleared `intr_flag` and a count of zero. A second collision, a start or a register write landing while a copy runs, is judged by the final pointer values and by the total number of write grants.

// File: rtl/blkcpy_pkg.sv
package blkcpy_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } cp_state_e;

   localparam logic [1:0] SZ_BYTE = 2'b00;
   localparam logic [1:0] SZ_HALF = 2'b01;
   localparam logic [1:0] SZ_WORD = 2'b10;

   localparam logic [1:0] SEL_SRC = 2'd0;
   localparam logic [1:0] SEL_DST = 2'd1;
   localparam logic [1:0] SEL_CNT = 2'd2;

   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         SZ_BYTE: size_bytes = 3'd1;
         SZ_HALF: size_bytes = 3'd2;
         default: size_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/blkcpy_ctrl.sv
module blkcpy_ctrl
   import blkcpy_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      irq,
   input  logic      mem_gnt,
   input  logic      cnt_zero,
   input  logic      cnt_last,
   output cp_state_e state,
   output logic      accept,
   output logic      capture,
   output logic      step,
   output logic      busy,
   output logic      done,
   output logic      intr_flag
);

   cp_state_e state_q;

   assign state   = state_q;
   assign busy    = (state_q != ST_IDLE);
   assign accept  = (state_q == ST_IDLE) && start && !cnt_zero;
   assign capture = (state_q == ST_READ)  && mem_gnt;
   assign step    = (state_q == ST_WRITE) && mem_gnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         done      <= 1'b0;
         intr_flag <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  intr_flag <= 1'b0;
                  if (cnt_zero) done    <= 1'b1;
                  else          state_q <= ST_READ;
               end
            end
            ST_READ: begin
               if (mem_gnt) state_q <= ST_WRITE;
            end
            ST_WRITE: begin
               if (mem_gnt) begin
                  if (cnt_last) begin
                     state_q <= ST_IDLE;
                     done    <= 1'b1;
                  end else if (irq) begin
                     state_q   <= ST_IDLE;
                     intr_flag <= 1'b1;
                  end else begin
                     state_q <= ST_READ;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt_last) |=> (done && !busy));

   assert_zero_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && cnt_zero) |=> (done && !busy));

   assert_intr_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(intr_flag) |-> (!busy && $past(irq) && $past(step)));

   assert_final_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt_last && irq) |=> (done && !intr_flag));

   assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !step) |=> busy);

endmodule

// File: rtl/blkcpy_regs.sv
module blkcpy_regs
   import blkcpy_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_sel,
   input  logic [AW-1:0] cfg_wdata,
   input  logic          step,
   input  logic [2:0]    esz,
   output logic [AW-1:0] src_ptr,
   output logic [AW-1:0] dst_ptr,
   output logic [CW-1:0] count
);

   localparam int PAD = AW - 3;

   logic [AW-1:0] inc;
   assign inc = {{PAD{1'b0}}, esz};

   initial begin
      assert (AW >= 4) else $error("blkcpy_regs: AW must be at least 4");
      assert (CW >= 1 && CW <= AW) else $error("blkcpy_regs: CW must lie in 1..AW");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_ptr <= '0;
         dst_ptr <= '0;
         count   <= '0;
      end else if (step) begin
         src_ptr <= src_ptr + inc;
         dst_ptr <= dst_ptr + inc;
         count   <= count - 1'b1;
      end else if (!busy && cfg_we) begin
         case (cfg_sel)
            SEL_SRC: src_ptr <= cfg_wdata;
            SEL_DST: dst_ptr <= cfg_wdata;
            SEL_CNT: count   <= cfg_wdata[CW-1:0];
            default: ;
         endcase
      end
   end

   assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (count == CW'($past(count) - 1'b1)));

   assert_ptr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (src_ptr - $past(src_ptr) == dst_ptr - $past(dst_ptr)));

   assert_cfg_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !step) |=> ($stable(src_ptr) && $stable(dst_ptr) && $stable(count)));

endmodule

// File: rtl/blkcpy_port.sv
module blkcpy_port
   import blkcpy_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  cp_state_e     state,
   input  logic          accept,
   input  logic          capture,
   input  logic [1:0]    elem_size,
   input  logic [AW-1:0] src_ptr,
   input  logic [AW-1:0] dst_ptr,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_gnt,
   output logic [2:0]    esz,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic [1:0]    mem_size
);

   localparam int LANES = DW / 8;

   logic [1:0]    sz_q;
   logic [DW-1:0] hold_q;
   logic [DW-1:0] lane_mask;

   initial begin
      assert (DW >= 32 && DW % 8 == 0)
         else $error("blkcpy_port: DW must be a multiple of 8, at least 32");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_mask[8*g +: 8] = (g < int'(esz)) ? 8'hFF : 8'h00;
   end

   assign esz       = size_bytes(sz_q);
   assign mem_req   = (state != ST_IDLE);
   assign mem_we    = (state == ST_WRITE);
   assign mem_addr  = mem_we ? dst_ptr : src_ptr;
   assign mem_wdata = hold_q;
   assign mem_size  = sz_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sz_q   <= SZ_BYTE;
         hold_q <= '0;
      end else begin
         if (accept) sz_q <= (elem_size == 2'b11) ? SZ_WORD : elem_size;
         if (capture) hold_q <= mem_rdata & lane_mask;
      end
   end

   assert_hold_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                 && $stable(mem_wdata) && $stable(mem_size)));

   assert_size_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $past(mem_req)) |-> $stable(mem_size));

endmodule

// File: rtl/blk_copy_engine.sv
module blk_copy_engine
   import blkcpy_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 12,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_sel,
   input  logic [AW-1:0] cfg_wdata,
   input  logic [1:0]    elem_size,
   input  logic          start,
   input  logic          irq,
   output logic          busy,
   output logic          done,
   output logic          intr_flag,
   output logic [AW-1:0] src_ptr,
   output logic [AW-1:0] dst_ptr,
   output logic [CW-1:0] count,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic [1:0]    mem_size,
   input  logic          mem_gnt,
   input  logic [DW-1:0] mem_rdata
);

   cp_state_e  state;
   logic       accept;
   logic       capture;
   logic       step;
   logic [2:0] esz;
   logic       cnt_zero;
   logic       cnt_last;

   assign cnt_zero = (count == '0);
   assign cnt_last = (count == CW'(1));

   blkcpy_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .irq       (irq),
      .mem_gnt   (mem_gnt),
      .cnt_zero  (cnt_zero),
      .cnt_last  (cnt_last),
      .state     (state),
      .accept    (accept),
      .capture   (capture),
      .step      (step),
      .busy      (busy),
      .done      (done),
      .intr_flag (intr_flag)
   );

   blkcpy_regs #(.AW(AW), .CW(CW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .step      (step),
      .esz       (esz),
      .src_ptr   (src_ptr),
      .dst_ptr   (dst_ptr),
      .count     (count)
   );

   blkcpy_port #(.AW(AW), .DW(DW)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .state     (state),
      .accept    (accept),
      .capture   (capture),
      .elem_size (elem_size),
      .src_ptr   (src_ptr),
      .dst_ptr   (dst_ptr),
      .mem_rdata (mem_rdata),
      .mem_gnt   (mem_gnt),
      .esz       (esz),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_size  (mem_size)
   );

   assert_write_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_gnt) |=> (mem_req && mem_we));

endmodule

// File: tb/blk_copy_engine_bench.sv
module blk_copy_engine_bench;

   localparam int AW = 8;
   localparam int CW = 8;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_sel = 2'd0;
   logic [AW-1:0] cfg_wdata = '0;
   logic [1:0]    elem_size = 2'd0;
   logic          start = 1'b0;
   logic          irq = 1'b0;
   logic          busy, done, intr_flag;
   logic [AW-1:0] src_ptr, dst_ptr;
   logic [CW-1:0] count;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [1:0]    mem_size;
   logic          mem_gnt = 1'b0;
   logic [DW-1:0] mem_rdata = '0;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   logic [7:0] mem [256];
   int wr_cnt = 0, acc_cnt = 0, done_cnt = 0, wdata_bad = 0;
   int wait_c = 0, lat = 0;

   always #4 clk = ~clk;

   blk_copy_engine #(.AW(AW), .CW(CW), .DW(DW)) u_blk_copy_engine (.*);

   function automatic int bsz(input int code);
      return (code == 0) ? 1 : (code == 1) ? 2 : 4;
   endfunction

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 7 + 3) & 8'hFF);
   endfunction

   // Memory model: grant after 0..2 wait cycles, driven on the falling edge
   always @(negedge clk) begin
      if (done) done_cnt++;
      if (mem_gnt) begin
         mem_gnt = 1'b0;
      end else if (mem_req) begin
         if (wait_c >= lat) begin
            wait_c = 0;
            lat = (lat + 1) % 3;
            acc_cnt++;
            if (mem_we) begin
               for (int k = 0; k < bsz(int'(mem_size)); k++)
                  mem[8'(int'(mem_addr) + k)] = mem_wdata[8*k +: 8];
               if ((mem_wdata >> (8 * bsz(int'(mem_size)))) != 0) wdata_bad++;
               wr_cnt++;
            end else begin
               mem_rdata = 32'hA5A5_A5A5;
               for (int k = 0; k < bsz(int'(mem_size)); k++)
                  mem_rdata[8*k +: 8] = mem[8'(int'(mem_addr) + k)];
            end
            mem_gnt = 1'b1;
         end else begin
            wait_c++;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] sel, input int val);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = AW'(val);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse_start(input int code);
      elem_size = 2'(code); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic init_mem();
      for (int a = 0; a < 256; a++) mem[a] = (a >= 8'h80) ? 8'hEE : pat(a);
   endtask

   task automatic wait_idle(output bit got_done);
      got_done = 1'b0;
      for (int t = 0; t < 4000; t++) begin
         if (done) got_done = 1'b1;
         if (!busy) break;
         @(negedge clk);
      end
      if (!got_done && done) got_done = 1'b1;
   endtask

   task automatic check_copy(input int sb, input int db, input int nbytes, input string tag);
      int errs = 0;
      for (int b = 0; b < nbytes; b++)
         if (mem[db + b] != pat(sb + b)) errs++;
      if (mem[db + nbytes] != 8'hEE) errs++;
      chk(errs == 0, tag, errs, 0);
   endtask

   initial begin
      bit gd;
      int w0, d0, a0, left, code, n, eb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(!busy && !done && !intr_flag && !mem_req, "R11 idle outputs", int'(busy), 0);
      chk(src_ptr == 0 && dst_ptr == 0 && count == 0, "R11 registers zero", int'(count), 0);

      // Sweep: all size codes and several lengths (R1 R2 R4)
      for (int c = 0; c < 4; c++) begin
         for (int ni = 0; ni < 3; ni++) begin
            n = (ni == 0) ? 1 : (ni == 1) ? 2 : 5;
            eb = bsz(c == 3 ? 2 : c);
            init_mem();
            wr_reg(2'd0, 8'h10); wr_reg(2'd1, 8'h80); wr_reg(2'd2, n);
            w0 = wr_cnt; d0 = done_cnt;
            pulse_start(c);
            chk(mem_size == ((c == 3) ? 2'b10 : 2'(c)), "R1 size code shown", int'(mem_size), c);
            wait_idle(gd);
            chk(gd && !busy, "R4 done with busy low", int'(gd), 1);
            @(negedge clk);
            chk(!done && done_cnt - d0 == 1, "R4 single done pulse", done_cnt - d0, 1);
            chk(src_ptr == 8'(8'h10 + n * eb), "R1 source advance", int'(src_ptr), 8'h10 + n * eb);
            chk(dst_ptr == 8'(8'h80 + n * eb), "R1 destination advance", int'(dst_ptr), 8'h80 + n * eb);
            chk(count == 0 && wr_cnt - w0 == n, "R4 count and writes", wr_cnt - w0, n);
            check_copy(8'h10, 8'h80, n * eb, "R2 destination bytes");
         end
      end
      chk(wdata_bad == 0, "R2 upper write lanes zero", wdata_bad, 0);

      // R5 zero count
      wr_reg(2'd2, 0);
      a0 = acc_cnt; d0 = done_cnt;
      pulse_start(0);
      chk(done && !busy, "R5 done next cycle", int'(done), 1);
      repeat (3) @(negedge clk);
      chk(acc_cnt == a0 && !mem_req, "R5 no memory access", acc_cnt - a0, 0);

      // R6 R7 interrupt partway and resume
      init_mem();
      wr_reg(2'd0, 8'h20); wr_reg(2'd1, 8'h90); wr_reg(2'd2, 6);
      w0 = wr_cnt;
      pulse_start(1);
      while (wr_cnt - w0 < 2) @(negedge clk);
      irq = 1'b1;
      wait_idle(gd);
      irq = 1'b0;
      left = int'(count);
      chk(intr_flag && !gd, "R6 interrupted flag", int'(intr_flag), 1);
      chk(left == 6 - (wr_cnt - w0) && left > 0, "R6 count matches progress", left, 6 - (wr_cnt - w0));
      chk(src_ptr == 8'(8'h20 + (6 - left) * 2), "R6 source resume point", int'(src_ptr), 8'h20 + (6 - left) * 2);
      check_copy(8'h20, 8'h90, (6 - left) * 2, "R6 partial copy exact");
      pulse_start(1);
      chk(!intr_flag, "R6 flag cleared by start", int'(intr_flag), 0);
      wait_idle(gd);
      chk(gd && wr_cnt - w0 == 6, "R7 resumed total writes", wr_cnt - w0, 6);
      check_copy(8'h20, 8'h90, 12, "R7 full copy after resume");

      // R6 R8: irq held high, each start moves one element; last one finishes
      init_mem();
      wr_reg(2'd0, 8'h30); wr_reg(2'd1, 8'hA0); wr_reg(2'd2, 4);
      irq = 1'b1;
      w0 = wr_cnt; n = 0;
      for (int s = 0; s < 10 && count != 0; s++) begin
         pulse_start(2);
         wait_idle(gd);
         n++;
         chk(wr_cnt - w0 == n, "R6 one element per run", wr_cnt - w0, n);
      end
      chk(n == 4 && gd && !intr_flag, "R8 final element completes", int'(intr_flag), 0);
      irq = 1'b0;
      check_copy(8'h30, 8'hA0, 16, "R7 stepwise copy");

      // R8 single element with irq high
      wr_reg(2'd0, 8'h40); wr_reg(2'd1, 8'hC0); wr_reg(2'd2, 1);
      irq = 1'b1;
      pulse_start(0);
      wait_idle(gd);
      irq = 1'b0;
      chk(gd && !intr_flag && count == 0, "R8 done beats irq", int'(gd), 1);

      // R9 R10 writes and start while busy ignored; code 3 selects nothing
      init_mem();
      wr_reg(2'd0, 8'h10); wr_reg(2'd1, 8'h80); wr_reg(2'd2, 3);
      wr_reg(2'd3, 8'h77);
      chk(src_ptr == 8'h10 && dst_ptr == 8'h80 && count == 3, "R9 select code 3 inert", int'(src_ptr), 8'h10);
      w0 = wr_cnt; d0 = done_cnt;
      pulse_start(2);
      wr_reg(2'd0, 8'h55);
      wr_reg(2'd2, 8'h09);
      pulse_start(2);
      chk(busy, "R10 still busy", int'(busy), 1);
      wait_idle(gd);
      @(negedge clk);
      chk(src_ptr == 8'h1C && dst_ptr == 8'h8C, "R9 busy writes ignored", int'(src_ptr), 8'h1C);
      chk(wr_cnt - w0 == 3 && done_cnt - d0 == 1, "R10 start while busy ignored", wr_cnt - w0, 3);
      check_copy(8'h10, 8'h80, 12, "R2 word copy");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule